// File: doc/BRIEF.md
# Interleaved Memory Target Decoder

This block maps a physical address onto the node and the physical memory channel that own it. A small table of ordered range rules is held on chip. Each rule carries an enable, an upper limit, a way-selection mode and a packed list of eight per-way targets. Each target field names a node code and a logical channel. For every lookup the block finds the first rule whose range holds the address. It derives an interleave way from address bits and reads that way's target. A per-channel remapping code then turns the logical channel into a physical one. The remapping covers plain mapping, mirrored pairs (reads split by an address parity) and sparing.

Software fills the table through a simple register write port. Lookups arrive as a request strobe with an address and a read/write flag. One clock later the block returns a response strobe, a valid flag, the node, the logical and physical channels, and the interleave degree of the matched rule. Translation of the address inside a channel is not done here.

Top module: `tgt_decoder`

## Requirements
- R1: After reset every rule is disabled, every remapping code is 0 and lockstep is off. While reset is held, `out_resp` and `out_valid` are 0, and the first lookup after reset returns `out_valid` = 0.
- R2: Rules are scanned from index 0 upward. The lower bound of rule i is the limit of rule i-1, whether or not rule i-1 is enabled, and rule 0 starts at 0. The first enabled rule with lower bound <= address < limit wins. When no rule matches, `out_valid` is 0. Limits compare against address bits [39:24], so the range granularity is 16 MiB.
- R3: In mode 0 the way is address bits [8:6].
- R4: In mode 1 the way is address bits [8:6] XOR address bits [18:16].
- R5: In mode 2, way bit 2 is address bit 6, and way bits [1:0] are address bits [39:6] taken modulo 3.
- R6: A matched rule in mode 3 gives `out_valid` = 0.
- R7: Way w reads target bits [4w+3:4w]. Within that field, bits [1:0] are the node code and bits [3:2] are the logical channel. Node code 1 gives node 0 and node code 2 gives node 1. Any other node code, or a logical channel of 3, gives `out_valid` = 0.
- R8: The remapping code of the logical channel sets the physical channel as follows: 1 gives 0, 2 gives 1, 4 gives 2, 5 gives 0 and 6 gives 1. Codes 0 and 7 keep the logical channel.
- R9: Under code 3, a read goes to physical channel 1 when address bits 24, 12 and 6 XOR to 1, and to channel 0 otherwise. A write keeps the logical channel.
- R10: With lockstep on, the physical channel equals the logical channel whatever the remapping code.
- R11: `out_degree` is the number of distinct 4-bit entries in the matched rule's target list (1 to 8).
- R12: `out_resp` is high exactly in the cycle after a cycle with `req_valid` high. When `out_valid` is 0, `out_node`, `out_lchan`, `out_pchan` and `out_degree` are 0.
- R13: Write index 2i loads the control word of rule i: bit 0 enable, bits [2:1] mode, bits [31:16] limit in 16 MiB units. Index 2i+1 loads its 32-bit target list. Index 2*RULES loads the remapping codes for logical channels 0, 1 and 2 in bits [2:0], [5:3] and [8:6], and lockstep in bit 9. A write takes effect for lookups issued from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Configuration register index |
| cfg_data | input | 32 | Configuration write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 40 | Physical address to decode |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| out_resp | output | 1 | Response strobe, one cycle after a request |
| out_valid | output | 1 | Decode succeeded |
| out_node | output | 1 | Owning node |
| out_lchan | output | 2 | Logical channel from the target list |
| out_pchan | output | 2 | Physical channel after remapping |
| out_degree | output | 4 | Interleave degree of the matched rule |

## Verification
Random addresses are spread over five ranges: a mode-0 rule, a disabled rule, a mode-1 rule, a mode-2 rule, a mode-3 rule, plus unmapped space above them. This separates range-priority errors from way-selection errors. Directed addresses sit on the last and first 16 MiB-granular address of neighbouring ranges, which exposes off-by-one limit compares. The same traffic is replayed under three sets of remapping codes and mixed read/write flags, then under lockstep, so the mirrored-read parity, sparing and bypass paths each produce distinct physical channels. A rewrite of one target list to a single repeated entry shows that table writes take effect and that the degree count drops to 1.

// File: rtl/tgt_dec_pkg.sv
package tgt_dec_pkg;

    localparam int WAYS    = 8;
    localparam int FIELD_W = 4;
    localparam int LIST_W  = WAYS * FIELD_W;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int LIMIT_W = 16;
    localparam int CFG_DW  = 32;
    localparam int CHANS   = 3;
    localparam int CODE_W  = 3;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'd0,
        MODE_HASH = 2'd1,
        MODE_MOD3 = 2'd2,
        MODE_BAD  = 2'd3
    } way_mode_e;

    typedef struct packed {
        logic               en;
        way_mode_e          mode;
        logic [LIMIT_W-1:0] lim;
    } rule_ctrl_t;

    typedef struct packed {
        logic       ok;
        logic       node;
        logic [1:0] lch;
        logic [1:0] pch;
        logic [3:0] degree;
    } dec_res_t;

    // Sum of two residues modulo 3.
    function automatic logic [1:0] add_mod3(input logic [1:0] a, input logic [1:0] b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

    // A 2-bit chunk reduced modulo 3.
    function automatic logic [1:0] fold_mod3(input logic [1:0] x);
        return (x == 2'd3) ? 2'd0 : x;
    endfunction

    function automatic logic [3:0] count_distinct(input logic [LIST_W-1:0] l);
        logic [3:0] n;
        logic       dup;
        n = '0;
        for (int i = 0; i < WAYS; i++) begin
            dup = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (l[FIELD_W*i +: FIELD_W] == l[FIELD_W*j +: FIELD_W]) dup = 1'b1;
            end
            if (!dup) n = n + 4'd1;
        end
        return n;
    endfunction

    function automatic logic [1:0] phys_channel(input logic [CODE_W-1:0] code,
                                                input logic [1:0] lch,
                                                input logic is_wr,
                                                input logic par,
                                                input logic lock);
        logic [1:0] p;
        p = lch;
        if (!lock) begin
            case (code)
                3'd1:    p = 2'd0;
                3'd2:    p = 2'd1;
                3'd4:    p = 2'd2;
                3'd5:    p = 2'd0;
                3'd6:    p = 2'd1;
                3'd3:    p = is_wr ? lch : {1'b0, par};
                default: p = lch;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/tgt_rule_table.sv
module tgt_rule_table
    import tgt_dec_pkg::*;
#(
    parameter int RULES  = 8,
    parameter int CFG_AW = $clog2(2*RULES+1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [CFG_AW-1:0]     idx,
    input  logic [CFG_DW-1:0]     data,
    output rule_ctrl_t            ctrl [RULES],
    output logic [LIST_W-1:0]     list [RULES],
    output logic [CODE_W-1:0]     map_code [CHANS],
    output logic                  lockstep
);

    localparam int GLOBAL_IDX = 2 * RULES;

    for (genvar i = 0; i < RULES; i++) begin : g_rule
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl[i] <= '0;
                list[i] <= '0;
            end else if (we) begin
                if (idx == CFG_AW'(2*i)) begin
                    ctrl[i].en   <= data[0];
                    ctrl[i].mode <= way_mode_e'(data[2:1]);
                    ctrl[i].lim  <= data[CFG_DW-1 -: LIMIT_W];
                end
                if (idx == CFG_AW'(2*i+1)) list[i] <= data[LIST_W-1:0];
            end
        end
    end

    for (genvar c = 0; c < CHANS; c++) begin : g_map
        always_ff @(posedge clk) begin
            if (rst)                                    map_code[c] <= '0;
            else if (we && idx == CFG_AW'(GLOBAL_IDX))  map_code[c] <= data[CODE_W*c +: CODE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                    lockstep <= 1'b0;
        else if (we && idx == CFG_AW'(GLOBAL_IDX))  lockstep <= data[CODE_W*CHANS];
    end

endmodule

// File: rtl/tgt_rule_match.sv
module tgt_rule_match
    import tgt_dec_pkg::*;
#(
    parameter int RULES = 8,
    parameter int IDX_W = (RULES > 1) ? $clog2(RULES) : 1
) (
    input  logic [LIMIT_W-1:0] addr_hi,
    input  rule_ctrl_t         ctrl [RULES],
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx
);

    logic [RULES-1:0] hv;

    for (genvar i = 0; i < RULES; i++) begin : g_cmp
        logic [LIMIT_W-1:0] base;
        if (i == 0) begin : g_first
            assign base = '0;
        end else begin : g_next
            assign base = ctrl[i-1].lim;
        end
        assign hv[i] = ctrl[i].en && (addr_hi >= base) && (addr_hi < ctrl[i].lim);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = RULES - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tgt_mod3_tree.sv
module tgt_mod3_tree
    import tgt_dec_pkg::*;
#(
    parameter int IN_W = 34
) (
    input  logic [IN_W-1:0] val,
    output logic [1:0]      res
);

    localparam int NCH   = (IN_W + 1) / 2;
    localparam int LVLS  = (NCH > 1) ? $clog2(NCH) : 0;
    localparam int NLEAF = 1 << LVLS;

    logic [2*NCH-1:0] padded;
    assign padded = (2*NCH)'(val);

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int N = NLEAF >> l;
        logic [1:0] r [N];
        for (genvar j = 0; j < N; j++) begin : g_node
            if (l == 0) begin : g_leaf
                if (j < NCH) begin : g_real
                    assign r[j] = fold_mod3(padded[2*j +: 2]);
                end else begin : g_pad
                    assign r[j] = 2'd0;
                end
            end else begin : g_sum
                assign r[j] = add_mod3(g_lvl[l-1].r[2*j], g_lvl[l-1].r[2*j+1]);
            end
        end
    end

    assign res = g_lvl[LVLS].r[0];

endmodule

// File: rtl/tgt_decoder.sv
module tgt_decoder
    import tgt_dec_pkg::*;
#(
    parameter int RULES    = 8,
    parameter int GRAN_LSB = 24,
    parameter int ADDR_W   = LIMIT_W + GRAN_LSB,
    parameter int CFG_AW   = $clog2(2*RULES+1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_idx,
    input  logic [CFG_DW-1:0] cfg_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              out_resp,
    output logic              out_valid,
    output logic              out_node,
    output logic [1:0]        out_lchan,
    output logic [1:0]        out_pchan,
    output logic [3:0]        out_degree
);

    localparam int IDX_W   = (RULES > 1) ? $clog2(RULES) : 1;
    localparam int LINE_LSB = 6;
    localparam int MOD_W   = ADDR_W - LINE_LSB;

    rule_ctrl_t           rule_ctrl [RULES];
    logic [LIST_W-1:0]    rule_list [RULES];
    logic [CODE_W-1:0]    map_code  [CHANS];
    logic                 lockstep_q;

    tgt_rule_table #(.RULES(RULES), .CFG_AW(CFG_AW)) u_table (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .idx      (cfg_idx),
        .data     (cfg_data),
        .ctrl     (rule_ctrl),
        .list     (rule_list),
        .map_code (map_code),
        .lockstep (lockstep_q)
    );

    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    tgt_rule_match #(.RULES(RULES), .IDX_W(IDX_W)) u_match (
        .addr_hi (req_addr[ADDR_W-1 -: LIMIT_W]),
        .ctrl    (rule_ctrl),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    logic [1:0] line_res;

    tgt_mod3_tree #(.IN_W(MOD_W)) u_mod3 (
        .val (req_addr[ADDR_W-1:LINE_LSB]),
        .res (line_res)
    );

    rule_ctrl_t          sel_ctrl;
    logic [LIST_W-1:0]   sel_list;
    logic [WAY_W-1:0]    way;
    logic [4:0]          shamt;
    logic [FIELD_W-1:0]  field;
    logic [1:0]          node_code;
    logic [1:0]          lch;
    logic [CODE_W-1:0]   code;
    logic                mirror_par;
    dec_res_t            res_d;
    dec_res_t            res_q;
    logic                resp_q;
    logic                addr_unused;

    assign addr_unused = ^req_addr;

    assign sel_ctrl = rule_ctrl[hit_idx];
    assign sel_list = rule_list[hit_idx];

    always_comb begin
        case (sel_ctrl.mode)
            MODE_LOW:  way = req_addr[8:6];
            MODE_HASH: way = req_addr[8:6] ^ req_addr[18:16];
            MODE_MOD3: way = {req_addr[6], line_res};
            default:   way = '0;
        endcase
    end

    assign shamt      = {way, 2'b00};
    assign field      = sel_list[shamt +: FIELD_W];
    assign node_code  = field[1:0];
    assign lch        = field[3:2];
    assign code       = (lch == 2'd3) ? '0 : map_code[lch];
    assign mirror_par = req_addr[24] ^ req_addr[12] ^ req_addr[6];

    always_comb begin
        res_d        = '0;
        res_d.ok     = hit && (sel_ctrl.mode != MODE_BAD) &&
                       (node_code == 2'd1 || node_code == 2'd2) && (lch != 2'd3);
        if (res_d.ok) begin
            res_d.node   = (node_code == 2'd2);
            res_d.lch    = lch;
            res_d.pch    = phys_channel(code, lch, req_write, mirror_par, lockstep_q);
            res_d.degree = count_distinct(sel_list);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= 1'b0;
            res_q  <= '0;
        end else begin
            resp_q <= req_valid;
            res_q  <= req_valid ? res_d : '0;
        end
    end

    assign out_resp   = resp_q;
    assign out_valid  = res_q.ok;
    assign out_node   = res_q.node;
    assign out_lchan  = res_q.lch;
    assign out_pchan  = res_q.pch;
    assign out_degree = res_q.degree;

endmodule

// File: rtl/tgt_decoder_chk.sv
module tgt_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       out_resp,
    input logic       out_valid,
    input logic       out_node,
    input logic [1:0] out_lchan,
    input logic [1:0] out_pchan,
    input logic [3:0] out_degree,
    input logic       lock
);

    // R12
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_resp);

    // R12
    idle_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_resp);

    // R12
    valid_needs_resp_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_resp);

    // R12
    invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_node && out_lchan == 2'd0 && out_pchan == 2'd0 && out_degree == 4'd0));

    // R11
    degree_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_degree >= 4'd1 && out_degree <= 4'd8));

    // R7
    lchan_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_lchan != 2'd3);

    // R8
    pchan_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_pchan != 2'd3);

    // R10
    lockstep_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(lock)) |-> out_pchan == out_lchan);

endmodule

bind tgt_decoder tgt_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .out_resp   (out_resp),
    .out_valid  (out_valid),
    .out_node   (out_node),
    .out_lchan  (out_lchan),
    .out_pchan  (out_pchan),
    .out_degree (out_degree),
    .lock       (lockstep_q)
);

// File: tb/tgt_decoder_tb.sv
`timescale 1ns/1ps
module tgt_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [31:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        out_resp, out_valid, out_node;
    logic [1:0]  out_lchan, out_pchan;
    logic [3:0]  out_degree;

    always #4 clk = ~clk;

    tgt_decoder u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .out_resp(out_resp), .out_valid(out_valid), .out_node(out_node),
        .out_lchan(out_lchan), .out_pchan(out_pchan), .out_degree(out_degree)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural model state
    int          m_en   [8];
    int          m_mode [8];
    int          m_lim  [8];
    bit [31:0]   m_list [8];
    int          m_map  [3];
    bit          m_lock;

    // Pending expectation
    bit    p_req = 0;
    int    p_ok, p_node, p_lch, p_pch, p_deg;
    string p_vtag = "R2";
    string p_ptag = "R8";

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic model(input longint unsigned a, input bit wr);
        int hit, base, way, fld, nc, lc, code;
        bit [15:0] seen;
        longint unsigned hi;
        hi = a >> 24;
        hit = -1; base = 0;
        for (int r = 0; r < 8; r++) begin
            if (m_en[r] != 0 && hi >= longint'(base) && hi < longint'(m_lim[r])) begin
                hit = r; break;
            end
            base = m_lim[r];
        end
        p_ok = 0; p_node = 0; p_lch = 0; p_pch = 0; p_deg = 0; p_ptag = "R8";
        if (hit < 0) begin p_vtag = "R2"; return; end
        way = 0;
        case (m_mode[hit])
            0: begin p_vtag = "R3"; way = int'((a >> 6) & 7); end
            1: begin p_vtag = "R4"; way = int'(((a >> 6) ^ (a >> 16)) & 7); end
            2: begin p_vtag = "R5"; way = int'(((a >> 6) & 1) * 4 + ((a >> 6) % 3)); end
            default: begin p_vtag = "R6"; return; end
        endcase
        fld = int'((m_list[hit] >> (4*way)) & 15);
        nc = fld & 3; lc = fld >> 2;
        if (!(nc == 1 || nc == 2) || lc == 3) begin
            if (p_vtag != "R5") p_vtag = "R7";
            return;
        end
        p_ok = 1;
        p_node = (nc == 2) ? 1 : 0;
        p_lch = lc;
        seen = '0;
        for (int w = 0; w < 8; w++) seen[(m_list[hit] >> (4*w)) & 15] = 1'b1;
        p_deg = $countones(seen);
        code = m_map[lc];
        if (m_lock) begin p_ptag = "R10"; p_pch = lc; end
        else begin
            case (code)
                1: p_pch = 0;
                2: p_pch = 1;
                4: p_pch = 2;
                5: p_pch = 0;
                6: p_pch = 1;
                3: begin
                    p_ptag = "R9";
                    p_pch = wr ? lc : int'(((a >> 24) ^ (a >> 12) ^ (a >> 6)) & 1);
                end
                default: p_pch = lc;
            endcase
        end
    endtask

    task automatic check_prev(input string vtag_ovr);
        string vt;
        vt = (vtag_ovr != "") ? vtag_ovr : p_vtag;
        chk("R12", "resp", 64'(out_resp), 64'(p_req));
        if (p_req) begin
            chk(vt, "valid", 64'(out_valid), 64'(p_ok));
            chk("R7", "node", 64'(out_node), 64'(p_node));
            chk("R7", "lchan", 64'(out_lchan), 64'(p_lch));
            chk(p_ptag, "pchan", 64'(out_pchan), 64'(p_pch));
            chk("R11", "degree", 64'(out_degree), 64'(p_deg));
        end
    endtask

    task automatic step(input bit v, input logic [39:0] a, input bit wr, input string vtag_ovr);
        @(negedge clk);
        check_prev(vtag_ovr);
        cfg_we = 1'b0;
        req_valid = v; req_addr = a; req_write = wr;
        p_req = v;
        if (v) model(64'(a), wr);
    endtask

    task automatic cfg_write(input int idx, input bit [31:0] d);
        @(negedge clk);
        check_prev("");
        req_valid = 1'b0;
        p_req = 0;
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_data = d;
        if (idx == 16) begin
            m_map[0] = int'(d[2:0]); m_map[1] = int'(d[5:3]); m_map[2] = int'(d[8:6]);
            m_lock = d[9];
        end else if (idx % 2 == 0) begin
            m_en[idx/2] = int'(d[0]); m_mode[idx/2] = int'(d[2:1]); m_lim[idx/2] = int'(d[31:16]);
        end else begin
            m_list[idx/2] = d;
        end
    endtask

    task automatic rule(input int r, input int en, input int mode, input int lim, input bit [31:0] list);
        cfg_write(2*r, (32'(lim) << 16) | (32'(mode) << 1) | 32'(en));
        cfg_write(2*r+1, list);
    endtask

    task automatic random_run(input int n);
        longint unsigned a;
        for (int i = 0; i < n; i++) begin
            a = {32'($urandom), 32'($urandom)} % (64'd48 << 24);
            step(1'b1, 40'(a), 1'($urandom & 1), "");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++) begin m_en[r] = 0; m_mode[r] = 0; m_lim[r] = 0; m_list[r] = '0; end
        for (int c = 0; c < 3; c++) m_map[c] = 0;
        m_lock = 0;

        // R1: reset holds outputs low
        repeat (3) @(negedge clk);
        chk("R1", "resp in reset", 64'(out_resp), 64'd0);
        chk("R1", "valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk); rst = 1'b0;
        step(1'b1, 40'h00_0100_0040, 1'b0, "");
        step(1'b0, '0, 1'b0, "R1");

        // R13: program table and mapper
        rule(0, 1, 0, 4,  32'h61A5_2961);
        rule(1, 0, 0, 8,  32'h1111_1111);
        rule(2, 1, 1, 16, 32'h53D9_6125);
        rule(3, 1, 2, 32, 32'h2295_1A61);
        rule(4, 1, 3, 40, 32'h1111_1111);
        cfg_write(16, {22'd0, 1'b0, 3'd4, 3'd6, 3'd3});

        // R2: boundaries between ranges
        step(1'b1, (40'd4 << 24) - 40'd1, 1'b0, "R2");
        step(1'b1, (40'd4 << 24), 1'b0, "R2");
        step(1'b1, (40'd8 << 24) - 40'd1, 1'b0, "R2");
        step(1'b1, (40'd8 << 24), 1'b0, "R2");
        step(1'b1, (40'd40 << 24), 1'b0, "R2");
        step(1'b1, 40'hFF_FFFF_FFC0, 1'b0, "R2");

        // R9: mirrored read parity patterns on logical channel 0 (rule0 way 0)
        step(1'b1, 40'h00_0000_0000, 1'b0, "R9");
        step(1'b1, 40'h00_0000_1000, 1'b0, "R9");
        step(1'b1, 40'h00_0100_1000, 1'b0, "R9");
        step(1'b1, 40'h00_0000_1000, 1'b1, "R9");

        // R3 R4 R5 R6 R7 R8 R9 R11: random traffic
        random_run(400);

        // R8: other remapping codes
        cfg_write(16, {22'd0, 1'b0, 3'd5, 3'd2, 3'd1});
        random_run(200);
        cfg_write(16, {22'd0, 1'b0, 3'd2, 3'd7, 3'd0});
        random_run(200);

        // R10: lockstep bypasses remapping
        cfg_write(16, {22'd0, 1'b1, 3'd4, 3'd3, 3'd3});
        random_run(200);
        cfg_write(16, {22'd0, 1'b0, 3'd4, 3'd6, 3'd3});

        // R13: rewriting a target list takes effect; degree drops to 1
        rule(0, 1, 0, 4, 32'h6666_6666);
        step(1'b1, 40'h00_0000_0140, 1'b0, "R13");
        step(1'b1, 40'h00_0000_01C0, 1'b1, "R13");
        step(1'b0, '0, 1'b0, "");
        step(1'b0, '0, 1'b0, "");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule